// File: doc/BRIEF.md
# UART Modem Control and Status Logic

This block holds the modem control register and the modem status register of a 16550-style serial port. Software writes the control register to drive the RTS, DTR, OUT1 and OUT2 pins and to select an internal loopback. The four incoming handshake lines (CTS, DSR, DCD, RI) pass through a two-stage synchroniser. The block records their current level and keeps sticky change flags, which software reads and clears through the status register. An OR of the change flags goes to the interrupt logic as a single level.

All pins use true sense: a 1 on a line input means that line is asserted, and a 1 on an output pin means the signal is asserted. Register accesses are single-cycle strobes with no back-pressure. A write is taken on the clock edge that ends the cycle in which `mcr_wr_en` is high. A status read returns `msr_rd_data` during the strobe cycle and clears the change flags on the edge that ends it. No stream interface is present, so every pin is a plain control or status signal.

In loopback the output pins are driven inactive and the external inputs are ignored. The control bits are fed back as status inputs, and changes in those fed-back values raise change flags under the same rules as external lines.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset, `msr_rd_data` is 0xB0 (DCD, DSR and CTS set), `mcr_rd_data` is 0x08 (only OUT2), `status_change` is 0, `pin_out2` is 1 and the other three pins are 0.
- R2: A control write keeps only bits 4:0: bit 4 loopback, bit 3 OUT2, bit 2 OUT1, bit 1 RTS, bit 0 DTR. From the next cycle `mcr_rd_data` reads those five bits, with bits 7:5 reading as zero.
- R3: With loopback clear, each pin equals its control bit. With loopback set, all four pins are 0.
- R4: Status bits are DCD bit 7, RI bit 6, DSR bit 5, CTS bit 4. When loopback is clear, a change on a line input is still absent from `msr_rd_data` after two clock edges and shows on the third edge.
- R5: A change of DCD, DSR or CTS sets its change bit: bit 3, bit 1 or bit 0 respectively. The bit stays set, across later changes in either direction, until a status read clears it.
- R6: Bit 2 is set only when RI goes from 1 to 0. A rising RI leaves bit 2 unchanged.
- R7: During a status read, `msr_rd_data` shows the value before clearing. Bits 3:0 are cleared on the edge that ends the read, except that a change detected on that same edge is kept.
- R8: In loopback, status bits 7, 6, 5 and 4 show OUT2, OUT1, DTR and RTS respectively, one edge after the control register takes them. The external line inputs have no effect on the status register.
- R9: Changes in the loopback values, including the change caused by entering or leaving loopback, set change bits by the rules of R5 and R6.
- R10: `status_change` is 1 exactly when any of status bits 3:0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_cts | input | 1 | Clear-to-send line, asynchronous |
| line_dsr | input | 1 | Data-set-ready line, asynchronous |
| line_dcd | input | 1 | Carrier-detect line, asynchronous |
| line_ri | input | 1 | Ring line, asynchronous |
| mcr_wr_en | input | 1 | Control register write strobe |
| mcr_wr_data | input | 8 | Control register write data |
| msr_rd_en | input | 1 | Status register read strobe (clears change bits) |
| mcr_rd_data | output | 8 | Control register readback |
| msr_rd_data | output | 8 | Status register readback |
| pin_rts | output | 1 | RTS output pin |
| pin_dtr | output | 1 | DTR output pin |
| pin_out1 | output | 1 | General output 1 |
| pin_out2 | output | 1 | General output 2 |
| status_change | output | 1 | Any change bit set, to interrupt logic |

## Verification
The hardest case to reach from the ports is a status read whose clearing edge is the same edge on which a new line change lands. The stimulus drives a line, counts exactly two edges for the synchroniser, and raises the read strobe for the third edge. It then checks that the old change bit is gone and the new one is kept. Trailing-edge ring detection and the loopback-entry change are reached by ordering the stimulus vectors so that RI rises and falls separately. In the same way, the status source switches between external and looped values with different contents.

// File: rtl/uart_modem_pkg.sv
package uart_modem_pkg;
  localparam int NLINES = 4;
  localparam int NCTL   = 5;

  // status line group, MSB first = MSR bit 7 down to bit 4
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mline_t;

  // control group, MSB first = MCR bit 4 down to bit 0
  typedef struct packed {
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } mctl_t;

  localparam mline_t LINE_RST = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};
  localparam mctl_t  CTL_RST  = '{loop: 1'b0, out2: 1'b1, out1: 1'b0, rts: 1'b0, dtr: 1'b0};
endpackage

// File: rtl/msr_line_sync.sv
module msr_line_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= RST_VAL;
    else        pipe[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s] <= RST_VAL;
      else        pipe[s] <= pipe[s-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/msr_ctl_reg.sv
module msr_ctl_reg
  import uart_modem_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [NCTL-1:0] wr_bits,
  output mctl_t           ctl_q,
  output logic            rts_o,
  output logic            dtr_o,
  output logic            out1_o,
  output logic            out2_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= CTL_RST;
    else if (wr_en) ctl_q <= mctl_t'(wr_bits);
  end

  // pins parked inactive while looped back
  always_comb begin
    rts_o  = ctl_q.rts  & ~ctl_q.loop;
    dtr_o  = ctl_q.dtr  & ~ctl_q.loop;
    out1_o = ctl_q.out1 & ~ctl_q.loop;
    out2_o = ctl_q.out2 & ~ctl_q.loop;
  end
endmodule

// File: rtl/msr_delta_track.sv
module msr_delta_track
  import uart_modem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  mline_t            src,
  input  logic              rd_clr,
  output mline_t            stat_q,
  output logic [NLINES-1:0] delta_q
);
  logic [NLINES-1:0] new_delta;

  always_comb begin
    new_delta[3] = stat_q.dcd ^ src.dcd;
    new_delta[2] = stat_q.ri & ~src.ri;       // trailing ring edge only
    new_delta[1] = stat_q.dsr ^ src.dsr;
    new_delta[0] = stat_q.cts ^ src.cts;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= LINE_RST;
      delta_q <= '0;
    end else begin
      stat_q  <= src;
      delta_q <= (rd_clr ? '0 : delta_q) | new_delta;
    end
  end
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import uart_modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_cts,
  input  logic       line_dsr,
  input  logic       line_dcd,
  input  logic       line_ri,
  input  logic       mcr_wr_en,
  input  logic [7:0] mcr_wr_data,
  input  logic       msr_rd_en,
  output logic [7:0] mcr_rd_data,
  output logic [7:0] msr_rd_data,
  output logic       pin_rts,
  output logic       pin_dtr,
  output logic       pin_out1,
  output logic       pin_out2,
  output logic       status_change
);
  localparam int PAD = 8 - NCTL;

  mctl_t             ctl_q;
  mline_t            ext_raw, ext_sync, loop_src, src_sel, stat_q;
  logic [NLINES-1:0] delta_q;
  logic [PAD-1:0]    unused_wr_hi;

  assign unused_wr_hi = mcr_wr_data[7:NCTL];

  assign ext_raw = '{dcd: line_dcd, ri: line_ri, dsr: line_dsr, cts: line_cts};

  msr_line_sync #(
    .WIDTH  (NLINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL(LINE_RST)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ext_raw),
    .dout (ext_sync)
  );

  msr_ctl_reg u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (mcr_wr_en),
    .wr_bits(mcr_wr_data[NCTL-1:0]),
    .ctl_q  (ctl_q),
    .rts_o  (pin_rts),
    .dtr_o  (pin_dtr),
    .out1_o (pin_out1),
    .out2_o (pin_out2)
  );

  always_comb begin
    loop_src = '{dcd: ctl_q.out2, ri: ctl_q.out1, dsr: ctl_q.dtr, cts: ctl_q.rts};
    src_sel  = ctl_q.loop ? loop_src : ext_sync;
  end

  msr_delta_track u_delta (
    .clk    (clk),
    .rst_n  (rst_n),
    .src    (src_sel),
    .rd_clr (msr_rd_en),
    .stat_q (stat_q),
    .delta_q(delta_q)
  );

  assign msr_rd_data   = {stat_q, delta_q};
  assign mcr_rd_data   = {{PAD{1'b0}}, ctl_q};
  assign status_change = |delta_q;
endmodule

// File: rtl/uart_modem_ctl_chk.sv
module uart_modem_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mcr_wr_en,
  input logic [7:0] mcr_wr_data,
  input logic       msr_rd_en,
  input logic [7:0] mcr_rd_data,
  input logic [7:0] msr_rd_data,
  input logic       pin_rts,
  input logic       pin_dtr,
  input logic       pin_out1,
  input logic       pin_out2,
  input logic       status_change
);
  a_r2_mcr_write: assert property (@(posedge clk) disable iff (!rst_n)
    mcr_wr_en |=> mcr_rd_data == {3'b000, $past(mcr_wr_data[4:0])});

  a_r3_loop_pins_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mcr_rd_data[4] |-> !(pin_rts | pin_dtr | pin_out1 | pin_out2));

  a_r5_dcd_delta: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd_data[7] != $past(msr_rd_data[7])) |-> msr_rd_data[3]);

  a_r5_dsr_delta: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd_data[5] != $past(msr_rd_data[5])) |-> msr_rd_data[1]);

  a_r5_cts_delta: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd_data[4] != $past(msr_rd_data[4])) |-> msr_rd_data[0]);

  a_r6_teri_only_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msr_rd_data[2]) |-> ($past(msr_rd_data[6]) && !msr_rd_data[6]));

  a_r6_fall_sets_teri: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(msr_rd_data[6]) |-> msr_rd_data[2]);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    msr_rd_en |=> (msr_rd_data[3:0] == 4'h0) ||
                  (msr_rd_data[7:4] != $past(msr_rd_data[7:4])));

  a_r8_loop_map: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mcr_rd_data[4]) |-> msr_rd_data[7:4] ==
      {$past(mcr_rd_data[3]), $past(mcr_rd_data[2]),
       $past(mcr_rd_data[0]), $past(mcr_rd_data[1])});

  a_r10_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_change) |-> msr_rd_data[7:4] != $past(msr_rd_data[7:4]));
endmodule

bind uart_modem_ctl uart_modem_ctl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mcr_wr_en    (mcr_wr_en),
  .mcr_wr_data  (mcr_wr_data),
  .msr_rd_en    (msr_rd_en),
  .mcr_rd_data  (mcr_rd_data),
  .msr_rd_data  (msr_rd_data),
  .pin_rts      (pin_rts),
  .pin_dtr      (pin_dtr),
  .pin_out1     (pin_out1),
  .pin_out2     (pin_out2),
  .status_change(status_change)
);

// File: tb/uart_modem_ctl_bench.sv
`timescale 1ns/1ps
module uart_modem_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_cts = 1'b1, line_dsr = 1'b1, line_dcd = 1'b1, line_ri = 1'b0;
  logic       mcr_wr_en = 1'b0;
  logic [7:0] mcr_wr_data = 8'h00;
  logic       msr_rd_en = 1'b0;
  logic [7:0] mcr_rd_data, msr_rd_data;
  logic       pin_rts, pin_dtr, pin_out1, pin_out2, status_change;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  uart_modem_ctl u_uart_modem_ctl (
    .clk(clk), .rst_n(rst_n),
    .line_cts(line_cts), .line_dsr(line_dsr), .line_dcd(line_dcd), .line_ri(line_ri),
    .mcr_wr_en(mcr_wr_en), .mcr_wr_data(mcr_wr_data), .msr_rd_en(msr_rd_en),
    .mcr_rd_data(mcr_rd_data), .msr_rd_data(msr_rd_data),
    .pin_rts(pin_rts), .pin_dtr(pin_dtr), .pin_out1(pin_out1), .pin_out2(pin_out2),
    .status_change(status_change)
  );

  // {lines dcd,ri,dsr,cts [19:16], wr [15], mcr [14:10], rd [9], exp_msr [8:1], exp_flag [0]}
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {4'b1011, 1'b0, 5'h00, 1'b0, 8'hB0, 1'b0},  // R1 idle
    {4'b1010, 1'b0, 5'h00, 1'b1, 8'hA1, 1'b1},  // R5 cts drop
    {4'b1110, 1'b0, 5'h00, 1'b0, 8'hE0, 1'b0},  // R6 ri rise, no delta
    {4'b1010, 1'b0, 5'h00, 1'b1, 8'hA4, 1'b1},  // R6 ri fall
    {4'b0000, 1'b0, 5'h00, 1'b0, 8'h0A, 1'b1},  // R5 dcd+dsr drop
    {4'b0011, 1'b0, 5'h00, 1'b1, 8'h3B, 1'b1},  // R5 sticky + cts
    {4'b0011, 1'b0, 5'h00, 1'b0, 8'h30, 1'b0},  // R7 cleared
    {4'b0011, 1'b1, 5'h1A, 1'b1, 8'h9A, 1'b1},  // R9 enter loop
    {4'b1111, 1'b0, 5'h00, 1'b0, 8'h90, 1'b0},  // R8 ext ignored
    {4'b1111, 1'b1, 5'h1D, 1'b1, 8'hE3, 1'b1},  // R8 R9 loop change
    {4'b1111, 1'b1, 5'h19, 1'b1, 8'hA4, 1'b1},  // R9 loop ri fall
    {4'b1111, 1'b1, 5'h03, 1'b1, 8'hF1, 1'b1}   // R9 leave loop
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic set_lines(input logic [3:0] l);
    {line_dcd, line_ri, line_dsr, line_cts} = l;
  endtask

  task automatic read_msr();
    @(negedge clk) msr_rd_en = 1'b1;
    @(negedge clk) msr_rd_en = 1'b0;
  endtask

  task automatic write_mcr(input logic [7:0] d);
    @(negedge clk) begin mcr_wr_en = 1'b1; mcr_wr_data = d; end
    @(negedge clk) mcr_wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 msr", msr_rd_data, 8'hB0);
    check("R1 mcr", mcr_rd_data, 8'h08);
    check("R1 flag", {7'd0, status_change}, 8'h00);
    check("R1 pins", {4'd0, pin_out2, pin_out1, pin_rts, pin_dtr}, 8'h08);

    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      v = VEC[i];
      @(negedge clk) begin
        set_lines(v[19:16]);
        mcr_wr_en   = v[15];
        mcr_wr_data = {3'b000, v[14:10]};
      end
      @(negedge clk) mcr_wr_en = 1'b0;
      repeat (3) @(negedge clk);
      check($sformatf("R5/R8 vec%0d msr", i), msr_rd_data, v[8:1]);
      check($sformatf("R10 vec%0d flag", i), {7'd0, status_change}, {7'd0, v[0]});
      if (v[9]) read_msr();
    end

    // R3 pins with loopback clear, mcr = 0x03
    check("R3 pins", {4'd0, pin_out2, pin_out1, pin_rts, pin_dtr}, 8'h03);

    // R4 synchroniser latency: lines 1111 -> 1110
    @(negedge clk) set_lines(4'b1110);
    @(negedge clk);
    @(negedge clk);
    check("R4 two edges", msr_rd_data, 8'hF0);
    @(negedge clk);
    check("R4 third edge", msr_rd_data, 8'hE1);
    read_msr();

    // R7 read collides with a new change
    @(negedge clk) set_lines(4'b1100);
    repeat (4) @(negedge clk);
    check("R7 pre", msr_rd_data, 8'hC2);
    set_lines(4'b0100);
    @(negedge clk);
    @(negedge clk) msr_rd_en = 1'b1;
    check("R7 read data", msr_rd_data, 8'hC2);
    @(negedge clk) msr_rd_en = 1'b0;
    check("R7 kept new delta", msr_rd_data, 8'h48);

    // R2 masking and R3 loopback pins
    write_mcr(8'hFF);
    check("R2 mask", mcr_rd_data, 8'h1F);
    check("R3 loop pins", {4'd0, pin_out2, pin_out1, pin_rts, pin_dtr}, 8'h00);
    write_mcr(8'hEF);
    check("R2 mask2", mcr_rd_data, 8'h0F);
    check("R3 all pins", {4'd0, pin_out2, pin_out1, pin_rts, pin_dtr}, 8'h0F);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule